// File: doc/BRIEF.md
# Panel Controller Register and Interrupt Unit

This block is the register file of a simple display panel controller. A 32-bit bus port with a valid strobe and a write strobe reaches six word registers: a control word, three timing words, a read-only status word and a subpanel word. The block keeps the panel mode fields, turns the stored dimension fields into the active width and height, and returns readback words in which some bit positions always read as one.

Three status flags (frame done, sync error, palette loaded) are set by single-cycle pulses from the frame-fetch logic and stay set until the enable bit changes. A level interrupt line combines these flags. Sync error raises it with no mask. Each of the other two flags has its own mask bit. When a control write changes the enable bit, the block updates the flags and emits a one-cycle strobe to the fetch logic.

Top module: `panel_ctl_regs`

## Requirements
- R1: After reset every stored field and flag is zero: irq and enable_chg are low, and lcd_width and lcd_height read 1. A control read gives 0xFE000C34, timing0 gives 0x0000000F, timing1 gives 0, timing2 gives 0xFC000000, status gives 0 and subpanel gives 0.
- R2: A write to offset 0x00 stores enable (bit 0), mono (bit 1), two interrupt mask bits (bits 4:3; bit 3 masks frame done and bit 4 masks palette loaded), panel-type select (bit 7) and palette mode (bits 21:20). It also keeps written bits under 0x01CFF300. A read returns those fields in place, with the panel-type bit also copied to bit 23, ORed with 0xFE000C34. The mode outputs follow from the clock edge of the write.
- R3: Offsets 0x04 and 0x08 each store the whole written word. Bits 9:0 hold the dimension minus one, so lcd_width (from 0x04) and lcd_height (from 0x08) equal that field plus 1, from 1 up to 1024. A read of 0x04 returns the word ORed with 0xF. A read of 0x08 returns it unchanged.
- R4: Offset 0x0C stores the whole written word, and a read returns it ORed with 0xFC000000.
- R5: Offset 0x14 stores the written word ANDed with 0xA1FFFFFF and returns it on read.
- R6: Status at offset 0x10 returns frame done at bit 0, sync error at bit 2 and palette loaded at bit 6, with all other bits zero. Writes to it change nothing.
- R7: A one-cycle set pulse sets its flag at the next clock edge. The flag stays set until an enable change clears it.
- R8: irq is high when sync error is set, when frame done is set with mask bit 3 set, or when palette loaded is set with mask bit 4 set. Otherwise it is low.
- R9: A control write that takes enable from 1 to 0 clears sync error, even if a sync set pulse arrives in the same cycle. It sets frame done unless the newly written palette mode is 1. Palette loaded is left as it is.
- R10: A control write that takes enable from 0 to 1 clears frame done and palette loaded, even if their set pulses arrive in the same cycle. Sync error is left as it is.
- R11: enable_chg is high for exactly the one cycle after a control write that changes bit 0. A control write that keeps bit 0 leaves it low.
- R12: Any other offset, including non-word-aligned ones, reads as zero, and writes to it change no register. bus_rdata is zero whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| set_frame_done | input | 1 | Pulse that sets frame done |
| set_sync_err | input | 1 | Pulse that sets sync error |
| set_pal_loaded | input | 1 | Pulse that sets palette loaded |
| irq | output | 1 | Level interrupt |
| enable_chg | output | 1 | One-cycle strobe after the enable bit changes |
| lcd_enable | output | 1 | Stored enable |
| lcd_mono | output | 1 | Stored mono select |
| lcd_tft | output | 1 | Stored panel-type select |
| lcd_pal_mode | output | 2 | Stored palette mode |
| lcd_width | output | DIM_W+1 | Active width in pixels |
| lcd_height | output | DIM_W+1 | Active height in lines |

## Verification
Assertions check on every cycle the following:
- The interrupt never rises without a flag, and a set sync error always raises it.
- The enable strobe only follows a real change of the enable bit.
- A rise or fall of enable leaves the flags in their required state.
- A status write never moves the flags.
- Reserved subpanel bits stay clear.

Only the bench's scenarios can show the readback images with their forced ones and mirrored bit, the width and height arithmetic across the field range, and the full mask-by-flag interrupt table. The same holds for which flag wins when a set pulse and an enable change land in the same cycle.

// File: rtl/panel_regs_pkg.sv
package panel_regs_pkg;
  localparam int DW      = 32;
  localparam int DIM_W   = 10;
  localparam int TOP_W   = DW - DIM_W;

  localparam logic [DW-1:0] CTRL_KEEP = 32'h01CF_F300;
  localparam logic [DW-1:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [DW-1:0] TIM0_ONES = 32'h0000_000F;
  localparam logic [DW-1:0] TIM2_ONES = 32'hFC00_0000;
  localparam logic [DW-1:0] SUB_KEEP  = 32'hA1FF_FFFF;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic          en;
    logic          mono;
    logic [1:0]    irq_mask;
    logic          tft;
    logic [1:0]    pal_mode;
    logic [DW-1:0] misc;
  } ctrl_t;

  function automatic reg_sel_e decode_sel(input logic [DW-1:0] a);
    case (a)
      32'h00:  return SEL_CTRL;
      32'h04:  return SEL_TIM0;
      32'h08:  return SEL_TIM1;
      32'h0C:  return SEL_TIM2;
      32'h10:  return SEL_STAT;
      32'h14:  return SEL_SUB;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctrl_image(input ctrl_t c);
    return c.misc | CTRL_ONES
         | (DW'(c.tft) << 23) | (DW'(c.pal_mode) << 20)
         | (DW'(c.tft) << 7)  | (DW'(c.irq_mask) << 3)
         | (DW'(c.mono) << 1) | DW'(c.en);
  endfunction

  function automatic logic [DW-1:0] status_image(input logic fd, input logic se,
                                                 input logic pl);
    return (DW'(pl) << 6) | (DW'(se) << 2) | DW'(fd);
  endfunction

  function automatic logic [DIM_W:0] dim_count(input logic [DIM_W-1:0] m1);
    return (DIM_W+1)'({1'b0, m1}) + (DIM_W+1)'(1);
  endfunction
endpackage

// File: rtl/pcr_cfg_bank.sv
module pcr_cfg_bank
  import panel_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_sel_e             sel,
  input  logic [DW-1:0]        wdata,
  output ctrl_t                ctrl,
  output logic [TOP_W-1:0]     t0_top,
  output logic [DIM_W-1:0]     w_m1,
  output logic [TOP_W-1:0]     t1_top,
  output logic [DIM_W-1:0]     h_m1,
  output logic [DW-1:0]        t2,
  output logic [DW-1:0]        sub,
  output logic                 en_rise,
  output logic                 en_fall,
  output logic                 keep_fd,
  output logic                 enable_chg
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign en_rise = ctrl_wr && wdata[0] && !ctrl.en;
  assign en_fall = ctrl_wr && !wdata[0] && ctrl.en;
  assign keep_fd = (wdata[21:20] == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      t0_top     <= '0;
      w_m1       <= '0;
      t1_top     <= '0;
      h_m1       <= '0;
      t2         <= '0;
      sub        <= '0;
      enable_chg <= 1'b0;
    end else begin
      enable_chg <= en_rise || en_fall;
      if (ctrl_wr) begin
        ctrl.en       <= wdata[0];
        ctrl.mono     <= wdata[1];
        ctrl.irq_mask <= wdata[4:3];
        ctrl.tft      <= wdata[7];
        ctrl.pal_mode <= wdata[21:20];
        ctrl.misc     <= wdata & CTRL_KEEP;
      end
      if (wr_en && sel == SEL_TIM0) {t0_top, w_m1} <= wdata;
      if (wr_en && sel == SEL_TIM1) {t1_top, h_m1} <= wdata;
      if (wr_en && sel == SEL_TIM2) t2 <= wdata;
      if (wr_en && sel == SEL_SUB)  sub <= wdata & SUB_KEEP;
    end
  end

  // R11
  en_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_chg |-> (ctrl.en != $past(ctrl.en)));

  // R5
  sub_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub & ~SUB_KEEP) == '0);
endmodule

// File: rtl/pcr_flag_unit.sv
module pcr_flag_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_fd,
  input  logic       set_se,
  input  logic       set_pl,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic       keep_fd,
  input  logic [1:0] irq_mask,
  output logic       fd,
  output logic       se,
  output logic       pl,
  output logic       irq
);
  logic fd_n, se_n, pl_n;

  always_comb begin
    fd_n = fd | set_fd;
    se_n = se | set_se;
    pl_n = pl | set_pl;
    if (en_fall) begin
      se_n = 1'b0;
      if (!keep_fd) fd_n = 1'b1;
    end
    if (en_rise) begin
      fd_n = 1'b0;
      pl_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd <= 1'b0;
      se <= 1'b0;
      pl <= 1'b0;
    end else begin
      fd <= fd_n;
      se <= se_n;
      pl <= pl_n;
    end
  end

  assign irq = se | (fd & irq_mask[0]) | (pl & irq_mask[1]);

  // R9
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !se);
  // R10
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!fd && !pl));
  // R7
  sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_se && !en_fall) |=> se);
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fd || se || pl) |-> !irq);
  // R8
  sync_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se |-> irq);
endmodule

// File: rtl/panel_ctl_regs.sv
module panel_ctl_regs
  import panel_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              set_frame_done,
  input  logic              set_sync_err,
  input  logic              set_pal_loaded,
  output logic              irq,
  output logic              enable_chg,
  output logic              lcd_enable,
  output logic              lcd_mono,
  output logic              lcd_tft,
  output logic [1:0]        lcd_pal_mode,
  output logic [DIM_W:0]    lcd_width,
  output logic [DIM_W:0]    lcd_height
);
  reg_sel_e         sel;
  logic             wr_en;
  ctrl_t            ctrl;
  logic [TOP_W-1:0] t0_top, t1_top;
  logic [DIM_W-1:0] w_m1, h_m1;
  logic [DW-1:0]    t2, sub;
  logic             en_rise, en_fall, keep_fd;
  logic             fd, se, pl;
  logic [DW-1:0]    img;

  assign sel   = decode_sel(DW'(bus_addr));
  assign wr_en = bus_valid && bus_write;

  pcr_cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(bus_wdata),
    .ctrl(ctrl), .t0_top(t0_top), .w_m1(w_m1), .t1_top(t1_top), .h_m1(h_m1),
    .t2(t2), .sub(sub), .en_rise(en_rise), .en_fall(en_fall),
    .keep_fd(keep_fd), .enable_chg(enable_chg)
  );

  pcr_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .set_fd(set_frame_done), .set_se(set_sync_err),
    .set_pl(set_pal_loaded), .en_rise(en_rise), .en_fall(en_fall),
    .keep_fd(keep_fd), .irq_mask(ctrl.irq_mask),
    .fd(fd), .se(se), .pl(pl), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: img = ctrl_image(ctrl);
      SEL_TIM0: img = {t0_top, w_m1} | TIM0_ONES;
      SEL_TIM1: img = {t1_top, h_m1};
      SEL_TIM2: img = t2 | TIM2_ONES;
      SEL_STAT: img = status_image(fd, se, pl);
      SEL_SUB:  img = sub;
      default:  img = '0;
    endcase
  end

  assign bus_rdata    = (bus_valid && !bus_write) ? img : '0;
  assign lcd_enable   = ctrl.en;
  assign lcd_mono     = ctrl.mono;
  assign lcd_tft      = ctrl.tft;
  assign lcd_pal_mode = ctrl.pal_mode;
  assign lcd_width    = dim_count(w_m1);
  assign lcd_height   = dim_count(h_m1);

  // R6
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_STAT && !set_frame_done && !set_sync_err && !set_pal_loaded)
      |=> $stable({fd, se, pl}));
  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_panel_ctl_regs.sv
module sim_panel_ctl_regs;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        set_frame_done = 1'b0, set_sync_err = 1'b0, set_pal_loaded = 1'b0;
  logic        irq, enable_chg, lcd_enable, lcd_mono, lcd_tft;
  logic [1:0]  lcd_pal_mode;
  logic [10:0] lcd_width, lcd_height;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  panel_ctl_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_frame_done(set_frame_done), .set_sync_err(set_sync_err),
    .set_pal_loaded(set_pal_loaded), .irq(irq), .enable_chg(enable_chg),
    .lcd_enable(lcd_enable), .lcd_mono(lcd_mono), .lcd_tft(lcd_tft),
    .lcd_pal_mode(lcd_pal_mode), .lcd_width(lcd_width), .lcd_height(lcd_height)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pulses: bit0 frame done, bit1 sync error, bit2 palette loaded
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [2:0] p);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    {set_pal_loaded, set_sync_err, set_frame_done} = p;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    {set_pal_loaded, set_sync_err, set_frame_done} = 3'b000;
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk);
    {set_pal_loaded, set_sync_err, set_frame_done} = p;
    @(negedge clk);
    {set_pal_loaded, set_sync_err, set_frame_done} = 3'b000;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_exp(input logic [31:0] v);
    logic [31:0] r;
    r = 32'hFE000C34 | (v & 32'h01CFF300);
    for (int b = 0; b < 32; b++)
      if ((b == 0 || b == 1 || b == 3 || b == 4 || b == 7 || b == 20 || b == 21) && v[b])
        r[b] = 1'b1;
    if (v[7]) r[23] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] stat_exp(input logic fd, input logic se, input logic pl);
    return 32'(fd) + 32'(se) * 4 + 32'(pl) * 64;
  endfunction

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] v;
    logic        prev_en;

    do_reset();
    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl", r, 32'hFE000C34);
    rd(8'h04, r); chk("R1 tim0", r, 32'h0000000F);
    rd(8'h08, r); chk("R1 tim1", r, 32'h0);
    rd(8'h0C, r); chk("R1 tim2", r, 32'hFC000000);
    rd(8'h10, r); chk("R1 status", r, 32'h0);
    rd(8'h14, r); chk("R1 sub", r, 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 chg", 32'(enable_chg), 0);
    chk("R1 width", 32'(lcd_width), 1);
    chk("R1 height", 32'(lcd_height), 1);

    // R2 / R11 control sweep
    prev_en = 1'b0;
    for (int i = 0; i < 96; i++) begin
      v = (32'(i) * 32'h2F1C5A93) ^ (32'(i) << 20) ^ 32'(i);
      wr(8'h00, v, 3'b000);
      chk("R11 strobe", 32'(enable_chg), 32'(v[0] != prev_en));
      prev_en = v[0];
      chk("R2 tft", 32'(lcd_tft), 32'(v[7]));
      chk("R2 mode", 32'(lcd_pal_mode), 32'(v[21:20]));
      chk("R2 mono_en", {30'b0, lcd_mono, lcd_enable}, {30'b0, v[1], v[0]});
      rd(8'h00, r); chk("R2 ctrl read", r, ctrl_exp(v));
      chk("R11 strobe one cycle", 32'(enable_chg), 0);
    end

    // R3 timing0/1 and R4 timing2, R5 subpanel sweeps
    for (int i = 0; i < 40; i++) begin
      v = (32'(i) * 32'h9E3779B9) ^ 32'(i * 29);
      wr(8'h04, v, 3'b000);
      wr(8'h08, ~v, 3'b000);
      wr(8'h0C, v ^ 32'h5A5A5A5A, 3'b000);
      wr(8'h14, ~v, 3'b000);
      chk("R3 width", 32'(lcd_width), (v % 1024) + 1);
      chk("R3 height", 32'(lcd_height), ((~v) % 1024) + 1);
      rd(8'h04, r); chk("R3 tim0 read", r, v | 32'hF);
      rd(8'h08, r); chk("R3 tim1 read", r, ~v);
      rd(8'h0C, r); chk("R4 tim2 read", r, (v ^ 32'h5A5A5A5A) | 32'hFC000000);
      rd(8'h14, r); chk("R5 sub read", r, ~v & 32'hA1FFFFFF);
    end
    wr(8'h04, 32'h3FF, 3'b000);
    chk("R3 width max", 32'(lcd_width), 1024);
    wr(8'h08, 32'hFFFFFC00, 3'b000);
    chk("R3 height min", 32'(lcd_height), 1);

    // R7 / R8 interrupt table (mask x flags)
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 8; f++) begin
        do_reset();
        wr(8'h00, 32'(m) << 3, 3'b000);
        pulse(3'(f));
        rd(8'h10, r);
        chk("R7 flags set", r, stat_exp(f[0], f[1], f[2]));
        chk("R8 irq", 32'(irq), 32'(f[1] | (f[0] & m[0]) | (f[2] & m[1])));
        @(negedge clk);
        rd(8'h10, r);
        chk("R7 sticky", r, stat_exp(f[0], f[1], f[2]));
      end
    end

    // R6 status writes ignored
    do_reset();
    pulse(3'b001);
    wr(8'h10, 32'hFFFFFFFF, 3'b000);
    rd(8'h10, r); chk("R6 status write ignored", r, 32'h1);
    wr(8'h10, 32'h0, 3'b000);
    rd(8'h10, r); chk("R6 status write zero ignored", r, 32'h1);
    chk("R6 irq unmasked frame", 32'(irq), 0);

    // R10 / R9 enable transitions
    do_reset();
    pulse(3'b111);
    wr(8'h00, 32'h1, 3'b000);
    chk("R11 rise strobe", 32'(enable_chg), 1);
    rd(8'h10, r); chk("R10 rise clears", r, 32'h4);
    chk("R8 sync unmasked", 32'(irq), 1);
    chk("R11 strobe drop", 32'(enable_chg), 0);
    wr(8'h00, 32'h1, 3'b000);
    chk("R11 no change no strobe", 32'(enable_chg), 0);
    pulse(3'b100);
    wr(8'h00, 32'h0, 3'b010);
    chk("R11 fall strobe", 32'(enable_chg), 1);
    rd(8'h10, r); chk("R9 fall sets fd clears se", r, 32'h41);
    wr(8'h00, 32'h1, 3'b101);
    rd(8'h10, r); chk("R10 rise beats set pulses", r, 32'h0);
    wr(8'h00, 32'h0010_0000, 3'b000);
    rd(8'h10, r); chk("R9 mode1 keeps fd", r, 32'h0);
    wr(8'h00, 32'h0020_0001, 3'b000);
    wr(8'h00, 32'h0020_0000, 3'b000);
    rd(8'h10, r); chk("R9 mode2 sets fd", r, 32'h1);

    // R12 undefined offsets
    do_reset();
    wr(8'h0C, 32'h12345678, 3'b000);
    wr(8'h04, 32'h00000123, 3'b000);
    wr(8'h18, 32'hFFFFFFFF, 3'b000);
    wr(8'h02, 32'hFFFFFFFF, 3'b000);
    wr(8'hFC, 32'hFFFFFFFF, 3'b000);
    rd(8'h00, r); chk("R12 ctrl untouched", r, 32'hFE000C34);
    rd(8'h0C, r); chk("R12 tim2 untouched", r, 32'hFE345678);
    rd(8'h14, r); chk("R12 sub untouched", r, 32'h0);
    chk("R12 width untouched", 32'(lcd_width), 32'h124);
    rd(8'h18, r); chk("R12 read 0x18", r, 32'h0);
    rd(8'h02, r); chk("R12 read misaligned", r, 32'h0);
    @(negedge clk);
    bus_addr = 8'h0C;
    #1 chk("R12 idle rdata", bus_rdata, 32'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule